// File: doc/BRIEF.md
# Decoded-Status Flag Register Group

This block keeps a one-bit "decoded" mark for every packet identifier in a network-coding receiver. An identifier is a 12-bit index that packs a source number and a generation number. A decoding engine raises the mark through the set channel once it has recovered a packet. The transmit side lowers the mark through the clear channel once that packet has left the node.

Two query ports let separate clients ask, in the same cycle, whether an identifier is already decoded. Each query returns a registered flag together with a one-cycle acknowledge. Writes land in the cycle they are presented. A query that hits the same identifier in that cycle sees the updated value, so a client never acts on a mark that is one cycle old.

Top module: `dsf_flag_group`

## Requirements
- R1: After reset, every acknowledge output is low and every identifier reads back as not decoded (flag 0).
- R2: A query port sampled with its request high answers in the next cycle: its acknowledge is high for exactly that one cycle, and its flag carries the mark of the requested index (1 = decoded, 0 = not decoded).
- R3: A query flag output is 0 in every cycle in which its acknowledge is low.
- R4: The two query ports work independently and concurrently. They give correct answers when they ask for the same index or for different indices in the same cycle.
- R5: A set operation happens in a cycle where the set request and the set info-valid are both high. It marks the given index as decoded and pulses the set acknowledge for one cycle in the next cycle. If only one of the two signals is high, nothing changes and no acknowledge is issued.
- R6: A clear operation happens in a cycle where the clear request and the clear info-valid are both high. It marks the given index as not decoded and pulses the clear acknowledge for one cycle in the next cycle. If only one of the two signals is high, nothing changes and no acknowledge is issued.
- R7: When a set and a clear target the same index in the same cycle, the index ends up decoded (set wins) and both acknowledges pulse.
- R8: A query in the same cycle as a set or clear of the same index returns the value after that write.
- R9: A set and a clear on different indices in the same cycle both take effect, and all other indices keep their marks.
- R10: All 4096 index values are addressable, including the lowest (0) and the highest (4095).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qry_req_a | input | 1 | Query port A request |
| qry_idx_a | input | IDX_W | Query port A identifier |
| qry_ack_a | output | 1 | Query port A answer valid (one cycle) |
| qry_flag_a | output | 1 | Query port A decoded mark |
| qry_req_b | input | 1 | Query port B request |
| qry_idx_b | input | IDX_W | Query port B identifier |
| qry_ack_b | output | 1 | Query port B answer valid (one cycle) |
| qry_flag_b | output | 1 | Query port B decoded mark |
| set_req | input | 1 | Set channel request |
| set_vld | input | 1 | Set channel info valid |
| set_idx | input | IDX_W | Identifier to mark decoded |
| set_ack | output | 1 | Set done (one cycle) |
| clr_req | input | 1 | Clear channel request |
| clr_vld | input | 1 | Clear channel info valid |
| clr_idx | input | IDX_W | Identifier to mark not decoded |
| clr_ack | output | 1 | Clear done (one cycle) |

## Verification
The bench goes after same-cycle collisions: set against clear on one index, and a query racing a write to the index it reads. A design with the wrong priority would leave the mark cleared. A design without forwarding would return the stale mark one cycle late. It also drives half-handshakes (request without info-valid and the reverse). A design that decodes only one of the two signals would then change a mark or emit a spurious acknowledge. Queries at indices 0 and 4095, and both ports on one index, expose address truncation and crossed ports. A long mixed stretch with indices drawn from a small range keeps collisions frequent.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  // number of concurrent query ports on the flag group
  localparam int unsigned DSF_NUM_QRY = 2;

  // entries addressed by an index of the given width
  function automatic int unsigned depth_of(input int unsigned idx_w);
    return 32'd1 << idx_w;
  endfunction
endpackage

// File: rtl/dsf_wr_chan.sv
// One write channel: qualifies request with info-valid and returns a
// registered one-cycle acknowledge for each accepted operation.
module dsf_wr_chan #(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  output logic             op_en,
  output logic [IDX_W-1:0] op_idx,
  output logic             ack
);
  assign op_en  = req & vld;
  assign op_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= op_en;
  end
endmodule

// File: rtl/dsf_flag_store.sv
// Flag storage with set-over-clear resolution. Exposes the value the
// array takes at the next edge so readers see same-cycle writes.
module dsf_flag_store #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned DEPTH = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [DEPTH-1:0] flags_nxt
);
  logic [DEPTH-1:0] flags_q;

  always_comb begin
    flags_nxt = flags_q;
    if (clr_en) flags_nxt[clr_idx] = 1'b0;
    if (set_en) flags_nxt[set_idx] = 1'b1;  // later write wins: set priority
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_nxt;
  end
endmodule

// File: rtl/dsf_qry_port.sv
// One query port: registered acknowledge and flag, flag forced low
// when no answer is being given.
module dsf_qry_port #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned DEPTH = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] idx,
  input  logic [DEPTH-1:0] flags_nxt,
  output logic             ack,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack  <= 1'b0;
      flag <= 1'b0;
    end else begin
      ack  <= req;
      flag <= req & flags_nxt[idx];
    end
  end
endmodule

// File: rtl/dsf_flag_group.sv
module dsf_flag_group #(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qry_req_a,
  input  logic [IDX_W-1:0] qry_idx_a,
  output logic             qry_ack_a,
  output logic             qry_flag_a,
  input  logic             qry_req_b,
  input  logic [IDX_W-1:0] qry_idx_b,
  output logic             qry_ack_b,
  output logic             qry_flag_b,
  input  logic             set_req,
  input  logic             set_vld,
  input  logic [IDX_W-1:0] set_idx,
  output logic             set_ack,
  input  logic             clr_req,
  input  logic             clr_vld,
  input  logic [IDX_W-1:0] clr_idx,
  output logic             clr_ack
);
  import dsf_pkg::*;

  localparam int unsigned DEPTH = depth_of(IDX_W);
  localparam int unsigned NQ    = DSF_NUM_QRY;

  logic             set_en, clr_en;
  logic [IDX_W-1:0] set_op_idx, clr_op_idx;
  logic [DEPTH-1:0] flags_nxt;

  logic [NQ-1:0]    q_req, q_ack, q_flag;
  logic [IDX_W-1:0] q_idx [NQ];

  dsf_wr_chan #(.IDX_W(IDX_W)) u_set_chan (
    .clk(clk), .rst(rst), .req(set_req), .vld(set_vld), .idx(set_idx),
    .op_en(set_en), .op_idx(set_op_idx), .ack(set_ack)
  );

  dsf_wr_chan #(.IDX_W(IDX_W)) u_clr_chan (
    .clk(clk), .rst(rst), .req(clr_req), .vld(clr_vld), .idx(clr_idx),
    .op_en(clr_en), .op_idx(clr_op_idx), .ack(clr_ack)
  );

  dsf_flag_store #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .set_en(set_en), .set_idx(set_op_idx),
    .clr_en(clr_en), .clr_idx(clr_op_idx),
    .flags_nxt(flags_nxt)
  );

  assign q_req    = {qry_req_b, qry_req_a};
  assign q_idx[0] = qry_idx_a;
  assign q_idx[1] = qry_idx_b;

  for (genvar g = 0; g < NQ; g++) begin : g_qry
    dsf_qry_port #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_qry (
      .clk(clk), .rst(rst), .req(q_req[g]), .idx(q_idx[g]),
      .flags_nxt(flags_nxt), .ack(q_ack[g]), .flag(q_flag[g])
    );
  end

  assign qry_ack_a  = q_ack[0];
  assign qry_flag_a = q_flag[0];
  assign qry_ack_b  = q_ack[1];
  assign qry_flag_b = q_flag[1];
endmodule

// File: rtl/dsf_flag_group_chk.sv
module dsf_flag_group_chk #(
  parameter int unsigned IDX_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             qry_req_a,
  input logic [IDX_W-1:0] qry_idx_a,
  input logic             qry_ack_a,
  input logic             qry_flag_a,
  input logic             qry_req_b,
  input logic [IDX_W-1:0] qry_idx_b,
  input logic             qry_ack_b,
  input logic             qry_flag_b,
  input logic             set_req,
  input logic             set_vld,
  input logic [IDX_W-1:0] set_idx,
  input logic             set_ack,
  input logic             clr_req,
  input logic             clr_vld,
  input logic [IDX_W-1:0] clr_idx,
  input logic             clr_ack
);
  p_qry_ack_a_r2: assert property (@(posedge clk) disable iff (rst)
    qry_req_a |=> qry_ack_a);
  p_qry_noack_a_r2: assert property (@(posedge clk) disable iff (rst)
    !qry_req_a |=> !qry_ack_a);
  p_qry_ack_b_r4: assert property (@(posedge clk) disable iff (rst)
    qry_req_b |=> qry_ack_b);
  p_flag_quiet_a_r3: assert property (@(posedge clk) disable iff (rst)
    !qry_ack_a |-> !qry_flag_a);
  p_flag_quiet_b_r3: assert property (@(posedge clk) disable iff (rst)
    !qry_ack_b |-> !qry_flag_b);
  p_set_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (set_req && set_vld) |=> set_ack);
  p_set_noack_r5: assert property (@(posedge clk) disable iff (rst)
    !(set_req && set_vld) |=> !set_ack);
  p_clr_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_req && clr_vld) |=> clr_ack);
  p_clr_noack_r6: assert property (@(posedge clk) disable iff (rst)
    !(clr_req && clr_vld) |=> !clr_ack);
  p_set_fwd_r8: assert property (@(posedge clk) disable iff (rst)
    (set_req && set_vld && qry_req_a && qry_idx_a == set_idx) |=> qry_flag_a);
  p_clr_fwd_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_req && clr_vld && qry_req_b && qry_idx_b == clr_idx &&
     !(set_req && set_vld && set_idx == clr_idx)) |=> !qry_flag_b);
  p_same_idx_r4: assert property (@(posedge clk) disable iff (rst)
    (qry_req_a && qry_req_b && qry_idx_a == qry_idx_b) |=> (qry_flag_a == qry_flag_b));
endmodule

bind dsf_flag_group dsf_flag_group_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/dsf_flag_group_tb_top.sv
`timescale 1ns/1ps
module dsf_flag_group_tb_top;
  localparam int IW = 12;
  localparam int N  = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic qa = 0, qb = 0, sr = 0, sv = 0, cr = 0, cv = 0;
  logic [IW-1:0] ia = '0, ib = '0, si = '0, ci = '0;
  logic ack_a, flag_a, ack_b, flag_b, s_ack, c_ack;

  always #4 clk = ~clk;  // 125 MHz

  dsf_flag_group #(.IDX_W(IW)) dut_i (
    .clk(clk), .rst(rst),
    .qry_req_a(qa), .qry_idx_a(ia), .qry_ack_a(ack_a), .qry_flag_a(flag_a),
    .qry_req_b(qb), .qry_idx_b(ib), .qry_ack_b(ack_b), .qry_flag_b(flag_b),
    .set_req(sr), .set_vld(sv), .set_idx(si), .set_ack(s_ack),
    .clr_req(cr), .clr_vld(cv), .clr_idx(ci), .clr_ack(c_ack)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit [N-1:0] model;
  bit armed = 0;
  string cur_tag = "R1", exp_tag = "R1";
  bit e_ack_a, e_flag_a, e_ack_b, e_flag_b, e_sack, e_cack;

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: next cycle's expected outputs from this cycle's inputs
  always @(posedge clk) begin
    bit [N-1:0] nxt;
    cyc++;
    if (rst) begin
      model = '0;
      {e_ack_a, e_flag_a, e_ack_b, e_flag_b, e_sack, e_cack} = '0;
      exp_tag = "R1";
    end else begin
      nxt = model;
      if (cr && cv) nxt[ci] = 1'b0;
      if (sr && sv) nxt[si] = 1'b1;
      e_ack_a  = qa;  e_flag_a = qa && nxt[ia];
      e_ack_b  = qb;  e_flag_b = qb && nxt[ib];
      e_sack   = sr && sv;
      e_cack   = cr && cv;
      model    = nxt;
      exp_tag  = cur_tag;
    end
    armed = 1;
    if (cyc == 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (armed) begin
    chk(exp_tag, "ack_a", ack_a, e_ack_a);
    chk(e_ack_a ? exp_tag : "R3", "flag_a", flag_a, e_flag_a);
    chk(exp_tag, "ack_b", ack_b, e_ack_b);
    chk(e_ack_b ? exp_tag : "R3", "flag_b", flag_b, e_flag_b);
    chk(exp_tag, "set_ack", s_ack, e_sack);
    chk(exp_tag, "clr_ack", c_ack, e_cack);
  end

  task automatic step(input string tag,
                      input bit q0, input int x0, input bit q1, input int x1,
                      input bit s_r, input bit s_v, input int s_i,
                      input bit c_r, input bit c_v, input int c_i);
    cur_tag = tag;
    qa = q0; ia = IW'(x0); qb = q1; ib = IW'(x1);
    sr = s_r; sv = s_v; si = IW'(s_i);
    cr = c_r; cv = c_v; ci = IW'(c_i);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset contents all zero
    step("R1", 1, 0, 1, 4095, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 77, 1, 2048, 0, 0, 0, 0, 0, 0);
    idle("R3");
    // R5: set, then read back; half handshakes ignored
    step("R5", 0, 0, 0, 0, 1, 1, 5, 0, 0, 0);
    step("R2", 1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 0, 7, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 8, 0, 0, 0);
    step("R5", 1, 7, 1, 8, 0, 0, 0, 0, 0, 0);
    // R6: clear, and half handshakes on the clear channel
    step("R6", 0, 0, 0, 0, 1, 1, 9, 1, 1, 5);
    step("R6", 1, 5, 1, 9, 0, 0, 0, 1, 0, 9);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1, 9);
    step("R6", 1, 9, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: set and clear on one index, set wins
    step("R7", 0, 0, 0, 0, 1, 1, 100, 1, 1, 100);
    step("R7", 1, 100, 1, 100, 0, 0, 0, 0, 0, 0);
    // R8: query racing writes on the same index
    step("R8", 1, 200, 0, 0, 1, 1, 200, 0, 0, 0);
    step("R8", 0, 0, 1, 200, 0, 0, 0, 1, 1, 200);
    step("R8", 1, 300, 1, 300, 1, 1, 300, 1, 1, 300);
    // R9 / R10: distinct indices at the ends of the range
    step("R10", 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    step("R9", 1, 0, 1, 4095, 1, 1, 4095, 1, 1, 0);
    step("R9", 1, 9, 1, 100, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 4095, 1, 0, 0, 0, 0, 0, 0, 0);
    // R4: ports on different and equal indices
    step("R4", 1, 4095, 1, 100, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 4095, 1, 4095, 0, 0, 0, 0, 0, 0);
    idle("R3");
    // R2: mixed traffic on a narrow window to force collisions
    for (int k = 0; k < 400; k++) begin
      step("R2", 1'($urandom), $urandom % 16, 1'($urandom), $urandom % 16,
           1'($urandom), 1'($urandom), $urandom % 16,
           1'($urandom), 1'($urandom), $urandom % 16);
    end
    idle("R2");
    idle("R2");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule